// File: doc/BRIEF.md
# Byte-Window Word Memory Bridge

This block gives a byte-wide host port a way into a 32-bit-word memory. The host sees eight register slots. Two of them hold an address pointer; the low one also carries a two-bit access-type code. Four more are data byte lanes of the addressed word. The remaining two slots are unused. The address the host writes is an offset inside the window, not a system address. The window spans a 15-bit byte space, which is 13 bits of word address.

There are two access styles. In byte access, every data-lane access goes straight to memory. A read fetches the word and returns the chosen lane. A write stores only that lane, using a byte enable. In the wide styles the block keeps a 32-bit holding word. Reading lane 0 fills it from memory, and the other lanes are then read from it. Writes to lanes 0 to 2 only fill it, and writing lane 3 sends all four lanes to memory in one write. In the auto-increment style, the pointer moves on by one word after a lane-3 read or a lane-3 commit.

The host raises `host_req` for one cycle and waits for the one-cycle `host_ack` before it issues the next request. Read data is valid on `host_rdata` while `host_ack` is high.

Top module: `ebr_bridge`

## Requirements
- R1: After reset both address slots read back zero, the access type is byte access, and no memory request is raised.
- R2: Slot 0 reads back all 8 bits as written. Slot 1 keeps only bits [6:0], and bit 7 reads 0. `mem_addr` is {slot1[6:0], slot0[7:2]}. Slot 0 bits [1:0] are the access code: 00 byte, 01 and 10 wide, 11 wide with auto-increment.
- R3: In byte access, a read of lane n (slots 2..5 map to lanes 0..3, and lane n is word bits [8n+7:8n]) issues one memory read at the current word and returns lane n. The pointer does not move.
- R4: In byte access, a write of lane n issues one memory write with only `mem_be` bit n set, carrying the written byte in lane n. The pointer does not move.
- R5: In the wide styles, a lane-0 read fetches the word from memory. Lane 1 to 3 reads return bytes of that held word and raise no memory request.
- R6: In the wide styles, writes to lanes 0 to 2 raise no memory request. A lane-3 write commits all four held bytes with `mem_be` = 1111.
- R7: With code 11, the word pointer advances by one after a lane-3 read or a lane-3 commit. Word 0x1FFF advances to word 0.
- R8: With codes 01 and 10, lane-3 reads and commits leave the pointer unchanged.
- R9: A write to either address slot clears the holding word, so bytes written to lanes before it are dropped.
- R10: `mem_rd` and `mem_wr` are one-cycle pulses and never high together. `mem_addr` holds steady while a request is outstanding. `host_ack` comes in the cycle after `mem_ready` is seen.
- R11: A request that needs no memory access is acknowledged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | One-cycle host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 3 | Slot: 0 addr low, 1 addr high, 2..5 lanes 0..3 |
| host_wdata | input | 8 | Host write byte |
| host_ack | output | 1 | One-cycle completion |
| host_rdata | output | 8 | Read byte, valid with host_ack |
| mem_addr | output | 13 | Word address |
| mem_rd | output | 1 | One-cycle read request |
| mem_wr | output | 1 | One-cycle write request |
| mem_be | output | 4 | Byte enables for writes |
| mem_wdata | output | 32 | Write word |
| mem_rdata | input | 32 | Read word, valid with mem_ready |
| mem_ready | input | 1 | Memory completion |

## Verification
Two things land in the same cycle in this block: the completion of a lane-3 commit and the auto-increment of the pointer. The write must carry the old address, and the pointer must move only after that write. The bench provokes this with auto-increment writes that run across two words and across word 0x1FFF. It checks that the memory model records the old address, then reads the address slots back to see the advanced or wrapped pointer. Memory latency is varied so that the ready edge falls on different cycles relative to the request.

// File: rtl/ebr_pkg.sv
package ebr_pkg;
  typedef enum logic [1:0] {
    MODE_BYTE  = 2'b00,
    MODE_WIDEA = 2'b01,
    MODE_WIDEB = 2'b10,
    MODE_AUTO  = 2'b11
  } acc_mode_e;

  localparam logic [2:0] SLOT_ALO = 3'd0;
  localparam logic [2:0] SLOT_AHI = 3'd1;

  function automatic logic [7:0] lane_get(input logic [31:0] w, input logic [1:0] ln);
    return w[8*ln +: 8];
  endfunction

  function automatic logic [31:0] lane_put(input logic [31:0] w, input logic [1:0] ln,
                                           input logic [7:0] b);
    logic [31:0] r;
    r = w;
    r[8*ln +: 8] = b;
    return r;
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] ln);
    return 4'b0001 << ln;
  endfunction
endpackage

// File: rtl/ebr_addr_regs.sv
module ebr_addr_regs #(
  parameter int ADDR_BITS = 15,
  localparam int HI_BITS = ADDR_BITS - 8,
  localparam int WORD_AW = ADDR_BITS - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [7:0]         wdata,
  input  logic               incr,
  output logic [7:0]         lo_q,
  output logic [HI_BITS-1:0] hi_q,
  output logic [WORD_AW-1:0] word_addr
);
  function automatic logic [WORD_AW-1:0] next_word(input logic [WORD_AW-1:0] a);
    return a + 1'b1;
  endfunction

  logic [WORD_AW-1:0] nxt;
  assign word_addr = {hi_q, lo_q[7:2]};
  assign nxt       = next_word(word_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr_lo) begin
      lo_q <= wdata;
    end else if (wr_hi) begin
      hi_q <= wdata[HI_BITS-1:0];
    end else if (incr) begin
      lo_q <= {nxt[5:0], lo_q[1:0]};
      hi_q <= nxt[WORD_AW-1:6];
    end
  end

  // R7
  incr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (incr && !wr_lo && !wr_hi && (&word_addr)) |=> (word_addr == '0));

  // R7
  incr_mode_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (incr && !wr_lo && !wr_hi) |=> $stable(lo_q[1:0]));
endmodule

// File: rtl/ebr_mem_seq.sv
module ebr_mem_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic start_rd,
  input  logic start_wr,
  input  logic mem_ready,
  output logic mem_rd,
  output logic mem_wr,
  output logic busy,
  output logic done
);
  logic wait_q, rd_q, wr_q;

  assign mem_rd = rd_q;
  assign mem_wr = wr_q;
  assign busy   = wait_q;
  assign done   = wait_q & mem_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
    end else begin
      rd_q <= start_rd;
      wr_q <= start_wr;
      if (start_rd || start_wr) wait_q <= 1'b1;
      else if (done)            wait_q <= 1'b0;
    end
  end

  // R10
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_q |=> !rd_q);
  // R10
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) wr_q |=> !wr_q);
  // R10
  no_dual_req_chk: assert property (@(posedge clk) disable iff (!rst_n) !(rd_q && wr_q));
  // R10
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rd || start_wr) |-> !wait_q);
endmodule

// File: rtl/ebr_bridge.sv
module ebr_bridge #(
  parameter int ADDR_BITS = 15,
  localparam int HI_BITS = ADDR_BITS - 8,
  localparam int WORD_AW = ADDR_BITS - 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [2:0]         host_addr,
  input  logic [7:0]         host_wdata,
  output logic               host_ack,
  output logic [7:0]         host_rdata,
  output logic [WORD_AW-1:0] mem_addr,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic [3:0]         mem_be,
  output logic [31:0]        mem_wdata,
  input  logic [31:0]        mem_rdata,
  input  logic               mem_ready
);
  import ebr_pkg::*;

  logic [7:0]         lo_q;
  logic [HI_BITS-1:0] hi_q;
  logic [WORD_AW-1:0] word_addr;
  acc_mode_e          mode;
  logic               wide, is_data, req_rd, req_wr;
  logic [1:0]         lane;
  logic               ev_fetch, ev_commit, ev_cancel, ev_incr, ev_quick;
  logic               busy, done;
  logic [31:0]        hold_q;
  logic [1:0]         op_lane_q;
  logic               op_rd_q, op_incr_q, ack_q;
  logic [3:0]         be_q;
  logic [7:0]         rdata_q, quick_rdata;

  assign mode    = acc_mode_e'(lo_q[1:0]);
  assign wide    = (mode != MODE_BYTE);
  assign is_data = (host_addr >= 3'd2) && (host_addr <= 3'd5);
  assign lane    = host_addr[1:0] + 2'd2;
  assign req_rd  = host_req & ~host_we;
  assign req_wr  = host_req &  host_we;

  assign ev_fetch  = req_rd & is_data & (~wide | (lane == 2'd0));
  assign ev_commit = req_wr & is_data & (~wide | (lane == 2'd3));
  assign ev_cancel = req_wr & ((host_addr == SLOT_ALO) | (host_addr == SLOT_AHI));
  assign ev_quick  = host_req & ~ev_fetch & ~ev_commit;
  assign ev_incr   = (ev_quick & req_rd & is_data & (lane == 2'd3) & (mode == MODE_AUTO))
                   | (done & ~op_rd_q & op_incr_q);

  ebr_addr_regs #(.ADDR_BITS(ADDR_BITS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lo    (req_wr && host_addr == SLOT_ALO),
    .wr_hi    (req_wr && host_addr == SLOT_AHI),
    .wdata    (host_wdata),
    .incr     (ev_incr),
    .lo_q     (lo_q),
    .hi_q     (hi_q),
    .word_addr(word_addr)
  );

  ebr_mem_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_rd (ev_fetch),
    .start_wr (ev_commit),
    .mem_ready(mem_ready),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .busy     (busy),
    .done     (done)
  );

  always_comb begin
    quick_rdata = 8'h00;
    if (host_addr == SLOT_ALO)      quick_rdata = lo_q;
    else if (host_addr == SLOT_AHI) quick_rdata = 8'(hi_q);
    else if (is_data)               quick_rdata = lane_get(hold_q, lane);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= '0;
      op_lane_q <= '0;
      op_rd_q   <= 1'b0;
      op_incr_q <= 1'b0;
      be_q      <= '0;
      ack_q     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      ack_q <= ev_quick | done;
      if (ev_cancel)                hold_q <= '0;
      else if (req_wr && is_data)   hold_q <= lane_put(hold_q, lane, host_wdata);
      else if (done && op_rd_q)     hold_q <= mem_rdata;
      if (ev_fetch || ev_commit) begin
        op_lane_q <= lane;
        op_rd_q   <= ev_fetch;
        op_incr_q <= (mode == MODE_AUTO) && (lane == 2'd3);
        be_q      <= wide ? 4'hF : lane_mask(lane);
      end
      if (ev_quick && req_rd)   rdata_q <= quick_rdata;
      else if (done && op_rd_q) rdata_q <= lane_get(mem_rdata, op_lane_q);
    end
  end

  assign host_ack   = ack_q;
  assign host_rdata = rdata_q;
  assign mem_addr   = word_addr;
  assign mem_be     = be_q;
  assign mem_wdata  = hold_q;

  // R4 R6
  commit_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (wide ? (mem_be == 4'hF) : ($countones(mem_be) == 1)));
  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(mem_addr));
  // R5
  no_fetch_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && is_data && wide && lane != 2'd0) |=> !mem_rd);
  // R11
  quick_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_quick |=> host_ack);
  // R10
  ack_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> host_ack);
endmodule

// File: tb/sim_ebr_bridge.sv
module sim_ebr_bridge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic host_ack;
  logic [7:0] host_rdata;
  logic [12:0] mem_addr;
  logic mem_rd, mem_wr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic mem_ready = 1'b0;

  int n_chk = 0, n_bad = 0;
  int lat = 1;
  int cnt = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [12:0] last_rd_a, last_wr_a, pend_a;
  logic [3:0]  last_be;
  logic [31:0] mem [0:255];

  always #2 clk = ~clk;

  ebr_bridge u0 (.*);

  always @(posedge clk) begin
    mem_ready <= 1'b0;
    if (mem_rd || mem_wr) begin
      cnt    <= lat;
      pend_a <= mem_addr;
      if (mem_rd) begin rd_cnt <= rd_cnt + 1; last_rd_a <= mem_addr; end
      if (mem_wr) begin
        wr_cnt <= wr_cnt + 1; last_wr_a <= mem_addr; last_be <= mem_be;
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[7:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end
    end else if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        mem_ready <= 1'b1;
        mem_rdata <= mem[pend_a[7:0]];
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_op(input bit we, input logic [2:0] a, input logic [7:0] d,
                         output logic [7:0] r, output int cyc);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    @(posedge clk);
    @(negedge clk);
    host_req = 1'b0;
    cyc = 1;
    while (!host_ack && cyc < 60) begin @(negedge clk); cyc++; end
    r = host_rdata;
    if (!host_ack) check(1'b0, "R10 ack timeout", 0, 1);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] r; int c;
    host_op(1'b1, a, d, r, c);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] r, output int c);
    host_op(1'b0, a, 8'h00, r, c);
  endtask

  task automatic set_ptr(input logic [12:0] w, input logic [1:0] code);
    wr(3'd1, {1'b0, w[12:6]});
    wr(3'd0, {w[5:0], code});
  endtask

  task automatic t_reset;
    logic [7:0] r; int c;
    check(!mem_rd && !mem_wr, "R1 no request after reset", {mem_rd, mem_wr}, 0);
    rd(3'd0, r, c); check(r == 8'h00, "R1 low slot", r, 0);
    check(c == 1, "R11 quick ack", c, 1);
    rd(3'd1, r, c); check(r == 8'h00, "R1 high slot", r, 0);
  endtask

  task automatic t_addr;
    logic [7:0] r; int c;
    wr(3'd0, 8'hA4); wr(3'd1, 8'hFF);
    rd(3'd0, r, c); check(r == 8'hA4, "R2 low readback", r, 8'hA4);
    rd(3'd1, r, c); check(r == 8'h7F, "R2 high bit7 ignored", r, 8'h7F);
    check(mem_addr == 13'h1FE9, "R2 mem_addr", mem_addr, 13'h1FE9);
  endtask

  task automatic t_byte_rd(input int l);
    logic [7:0] r; int c, n0;
    lat = l;
    mem[5] = 32'h44332211;
    set_ptr(13'd5, 2'b00);
    n0 = rd_cnt;
    rd(3'd4, r, c);
    check(r == 8'h33, "R3 byte lane2", r, 8'h33);
    check(rd_cnt == n0 + 1 && last_rd_a == 13'd5, "R3 one read at word", rd_cnt - n0, 1);
    check(c == l + 3, "R10 ack after ready", c, l + 3);
    check(mem_addr == 13'd5, "R3 pointer kept", mem_addr, 5);
  endtask

  task automatic t_byte_wr;
    mem[6] = 32'h11223344;
    set_ptr(13'd6, 2'b00);
    wr(3'd3, 8'hAB);
    check(mem[6] == 32'h1122AB44, "R4 lane1 only", mem[6], 32'h1122AB44);
    check(last_be == 4'b0010, "R4 be", last_be, 4'b0010);
    check(mem_addr == 13'd6, "R4 pointer kept", mem_addr, 6);
  endtask

  task automatic t_wide_rd;
    logic [7:0] r; int c, n0;
    mem[7] = 32'hDDCCBBAA;
    set_ptr(13'd7, 2'b01);
    n0 = rd_cnt;
    rd(3'd2, r, c); check(r == 8'hAA, "R5 lane0 fetch", r, 8'hAA);
    rd(3'd3, r, c); check(r == 8'hBB && c == 1, "R5 lane1 held", r, 8'hBB);
    rd(3'd4, r, c); check(r == 8'hCC, "R5 lane2 held", r, 8'hCC);
    rd(3'd5, r, c); check(r == 8'hDD, "R5 lane3 held", r, 8'hDD);
    check(rd_cnt == n0 + 1, "R5 single fetch", rd_cnt - n0, 1);
    check(mem_addr == 13'd7, "R8 no incr code01", mem_addr, 7);
  endtask

  task automatic t_wide_wr;
    int n0;
    mem[8] = 32'h0;
    set_ptr(13'd8, 2'b10);
    n0 = wr_cnt;
    wr(3'd2, 8'h01); wr(3'd3, 8'h02); wr(3'd4, 8'h03);
    check(wr_cnt == n0, "R6 no early write", wr_cnt - n0, 0);
    wr(3'd5, 8'h04);
    check(mem[8] == 32'h04030201, "R6 full commit", mem[8], 32'h04030201);
    check(last_be == 4'hF, "R6 be all", last_be, 4'hF);
    check(mem_addr == 13'd8, "R8 no incr code10", mem_addr, 8);
  endtask

  task automatic t_auto;
    logic [7:0] r; int c;
    set_ptr(13'd9, 2'b11);
    for (int i = 0; i < 8; i++) wr(3'(2 + i % 4), 8'(8'h10 + i));
    check(mem[9] == 32'h13121110 && mem[10] == 32'h17161514, "R7 two words",
          mem[10], 32'h17161514);
    check(last_wr_a == 13'd10, "R7 commit old addr", last_wr_a, 10);
    rd(3'd0, r, c); check(r == 8'h2F, "R7 pointer advanced", r, 8'h2F);
    set_ptr(13'd9, 2'b11);
    for (int i = 0; i < 8; i++) begin
      rd(3'(2 + i % 4), r, c);
      check(r == 8'(8'h10 + i), "R7 auto read", r, 8'h10 + i);
    end
    check(mem_addr == 13'd11, "R7 read advance", mem_addr, 11);
  endtask

  task automatic t_wrap;
    logic [7:0] r; int c;
    lat = 2;
    set_ptr(13'h1FFF, 2'b11);
    for (int i = 0; i < 4; i++) wr(3'(2 + i), 8'(8'hE0 + i));
    check(last_wr_a == 13'h1FFF && mem[255] == 32'hE3E2E1E0, "R7 commit at top",
          last_wr_a, 13'h1FFF);
    rd(3'd0, r, c); check(r == 8'h03, "R7 wrap low", r, 8'h03);
    rd(3'd1, r, c); check(r == 8'h00, "R7 wrap high", r, 8'h00);
  endtask

  task automatic t_cancel;
    mem[12] = 32'hFFFFFFFF;
    set_ptr(13'd12, 2'b10);
    wr(3'd2, 8'h55); wr(3'd3, 8'h66);
    wr(3'd0, {6'd12, 2'b10});
    wr(3'd5, 8'h77);
    check(mem[12] == 32'h77000000, "R9 pending dropped", mem[12], 32'h77000000);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset;
    t_addr;
    t_byte_rd(1);
    t_byte_rd(3);
    t_byte_wr;
    t_wide_rd;
    t_wide_wr;
    t_auto;
    t_wrap;
    t_cancel;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #80000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule